// File: doc/BRIEF.md
# Frame-Synchronised Control Register Buffer

This block is the register side of a byte-oriented serial-bus slave that configures a monitor video front end. A separate bit-level engine hands it a start marker, a stop marker and received bytes, and it returns the acknowledge decision for each byte in the cycle that byte is presented. The first byte after a start is a subaddress. Its top bit picks the write mode and its lower seven bits pick the register. The data bytes that follow are then written to the register bank.

In direct mode each accepted data byte is written at once, and the register pointer auto-increments. In buffered mode only one data byte is taken, into a single holding slot. That byte is committed on the first frame-blanking strobe after the transmission's stop. Until the commit, every further transmission is refused. After the commit the receiver stays deaf for a programmable number of cycles. A power-on flag refuses data bytes until the control register is addressed. The control bits and all alignment registers are exposed in parallel.

Top module: `vbl_regbuf`

## Requirements
- R1: Reset values: control bit 1 (feedback polarity) is 1. Control bits 0, 2 and 3, brightness, contrast, OSD gain, all channel gains, all channel references, AC black level and pedestal depth are 0. The power-on flag is set.
- R2: Subaddress bit 7 = 1 selects buffered mode and bit 7 = 0 selects direct mode. Bits 6:0 index the register. The map is: 00 control (bit0 grey-tracking off, bit1 feedback polarity, bit2 video off, bit3 OSD off), 01 brightness, 02 contrast, 03 OSD gain (4 bits), 04..06 gain of channels 0..2, 07..09 feedback reference of channels 0..2, 0A AC black level (3 bits), 0B pedestal depth (2 bits). Unused upper bits are dropped.
- R3: In direct mode each data byte is acknowledged and appears at the outputs one cycle after it is presented. The pointer then advances by one, and it stays at 0B once it reaches 0B.
- R4: A subaddress above 0B is acknowledged. Its data bytes are acknowledged (only the first one in buffered mode), no register changes, and no buffered lock is taken.
- R5: While the power-on flag is set, subaddresses are acknowledged but data bytes are not acknowledged and are discarded. A subaddress whose index is 00 clears the flag, and the data that follows it is accepted.
- R6: In buffered mode the first data byte is acknowledged and held. Later bytes of the same transmission are not acknowledged. No register changes before the commit.
- R7: The held byte is written on the first blanking strobe in a cycle after the stop cycle. A strobe in the stop cycle or earlier does not commit. The register shows the byte one cycle after the committing strobe.
- R8: From the acknowledged buffered data byte until the commit, the subaddress and all bytes of any new transmission are not acknowledged.
- R9: For DEAD_CYC cycles after the committing strobe cycle, every subaddress is not acknowledged. A subaddress in the next cycle after that window is acknowledged.
- R10: Reset discards a held byte that is waiting for a strobe. A later strobe writes nothing, and new transmissions are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start marker from the bit engine |
| stop_i | input | 1 | Stop marker from the bit engine |
| byte_vld_i | input | 1 | Received byte valid for one cycle |
| byte_i | input | 8 | Received byte |
| vblank_edge_i | input | 1 | One-cycle strobe on the frame-blanking leading edge |
| ack_o | output | 1 | Acknowledge decision for the byte presented this cycle |
| gray_track_off_o | output | 1 | Control bit 0 |
| fb_pos_o | output | 1 | Control bit 1, feedback polarity |
| video_off_o | output | 1 | Control bit 2 |
| osd_off_o | output | 1 | Control bit 3 |
| bright_o | output | 8 | Brightness |
| contrast_o | output | 8 | Contrast |
| osd_gain_o | output | 4 | OSD contrast |
| chan_gain_o | output | 24 | Channel gains, channel n at bits 8n+7:8n |
| chan_ref_o | output | 24 | Feedback references, channel n at bits 8n+7:8n |
| ac_black_o | output | 3 | AC-coupling black level |
| ped_depth_o | output | 2 | Pedestal blanking depth |

## Verification
Two functions can meet in one cycle. One is the blanking strobe that commits the held byte. The other is the stop that arms the commit, or a byte of a new transmission that arrives while the slot is still held. The bench places a strobe in the same cycle as the stop and also between the held byte and the stop. It expects the register to stay unchanged until a later strobe. It also places subaddresses exactly on the last cycle of the dead window and on the first cycle after it, and expects a refusal and then an acknowledge.

// File: rtl/vbl_regbuf_pkg.sv
package vbl_regbuf_pkg;
  localparam int NCH    = 3;
  localparam int DW     = 8;
  localparam int CTRL_W = 4;
  localparam int OSD_W  = 4;
  localparam int BLK_W  = 3;
  localparam int PED_W  = 2;
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0010;

  localparam logic [6:0] A_CTRL   = 7'd0;
  localparam logic [6:0] A_BRIGHT = 7'd1;
  localparam logic [6:0] A_CONTR  = 7'd2;
  localparam logic [6:0] A_OSD    = 7'd3;
  localparam logic [6:0] A_GAIN   = 7'd4;
  localparam logic [6:0] A_REF    = A_GAIN + 7'(NCH);
  localparam logic [6:0] A_BLACK  = A_REF + 7'(NCH);
  localparam logic [6:0] A_PED    = A_BLACK + 7'd1;
  localparam logic [6:0] A_LAST   = A_PED;

  typedef enum logic [1:0] {PH_IDLE, PH_SUB, PH_DATA, PH_REJ} phase_e;

  typedef struct packed {
    logic          we;
    logic [6:0]    idx;
    logic [DW-1:0] data;
  } wr_t;
endpackage

// File: rtl/vbl_rx_ctrl.sv
module vbl_rx_ctrl
  import vbl_regbuf_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       locked_i,
  input  logic       dead_i,
  output logic       ack_o,
  output wr_t        dwr_o,
  output wr_t        load_o,
  output logic       end_buf_o
);
  phase_e     phase_q;
  logic       mode_buf_q, taken_q, por_q;
  logic [6:0] idx_q;
  logic       ack_dec, acc_data, in_map;

  always_comb begin
    unique case (phase_q)
      PH_SUB:  ack_dec = !dead_i && !locked_i;
      PH_DATA: ack_dec = !por_q && (!mode_buf_q || !taken_q);
      default: ack_dec = 1'b0;
    endcase
  end

  assign ack_o    = byte_vld_i && ack_dec;
  assign acc_data = ack_o && (phase_q == PH_DATA);
  assign in_map   = (idx_q <= A_LAST);

  assign dwr_o.we    = acc_data && !mode_buf_q && in_map;
  assign dwr_o.idx   = idx_q;
  assign dwr_o.data  = byte_i;
  assign load_o.we   = acc_data && mode_buf_q && in_map;
  assign load_o.idx  = idx_q;
  assign load_o.data = byte_i;
  assign end_buf_o   = stop_i && (phase_q == PH_DATA) && mode_buf_q && (taken_q || acc_data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      mode_buf_q <= 1'b0;
      taken_q    <= 1'b0;
      por_q      <= 1'b1;
      idx_q      <= '0;
    end else if (start_i) begin
      phase_q <= PH_SUB;
    end else begin
      if (byte_vld_i) begin
        if (phase_q == PH_SUB) begin
          if (ack_o) begin
            phase_q    <= PH_DATA;
            mode_buf_q <= byte_i[7];
            idx_q      <= byte_i[6:0];
            taken_q    <= 1'b0;
            if (byte_i[6:0] == A_CTRL) por_q <= 1'b0;
          end else begin
            phase_q <= PH_REJ;
          end
        end else if (acc_data) begin
          if (mode_buf_q)            taken_q <= 1'b1;
          else if (idx_q < A_LAST)   idx_q   <= idx_q + 7'd1;
        end
      end
      if (stop_i) phase_q <= PH_IDLE;
    end
  end

  p_por_blocks_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_q |-> (!dwr_o.we && !load_o.we));
  p_ptr_saturates_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dwr_o.we && dwr_o.idx == A_LAST && !start_i) |=> (idx_q == A_LAST));
endmodule

// File: rtl/vbl_hold_buf.sv
module vbl_hold_buf
  import vbl_regbuf_pkg::*;
#(
  parameter int DEAD_CYC = 750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  wr_t  load_i,
  input  logic end_buf_i,
  input  logic vblank_i,
  output logic locked_o,
  output logic dead_o,
  output wr_t  commit_o
);
  localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);

  logic          valid_q, armed_q;
  logic [6:0]    idx_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;

  assign commit_o.we   = vblank_i && armed_q;
  assign commit_o.idx  = idx_q;
  assign commit_o.data = data_q;
  assign locked_o      = valid_q;
  assign dead_o        = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      armed_q <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (load_i.we) begin
        valid_q <= 1'b1;
        idx_q   <= load_i.idx;
        data_q  <= load_i.data;
      end
      if (end_buf_i && (valid_q || load_i.we)) armed_q <= 1'b1;
      if (commit_o.we) begin
        valid_q <= 1'b0;
        armed_q <= 1'b0;
        cnt_q   <= CW'(DEAD_CYC);
      end else if (dead_o) begin
        cnt_q <= cnt_q - CW'(1);
      end
    end
  end

  p_single_slot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> !load_i.we);
  p_dead_no_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |-> !load_i.we);
  p_commit_frees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o.we |=> (!valid_q && dead_o));
endmodule

// File: rtl/vbl_reg_file.sv
module vbl_reg_file
  import vbl_regbuf_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  wr_t                 dwr_i,
  input  wr_t                 cwr_i,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [DW-1:0]       bright_o,
  output logic [DW-1:0]       contrast_o,
  output logic [OSD_W-1:0]    osd_o,
  output logic [NCH*DW-1:0]   gain_o,
  output logic [NCH*DW-1:0]   ref_o,
  output logic [BLK_W-1:0]    black_o,
  output logic [PED_W-1:0]    ped_o
);
  wr_t wr;
  assign wr = cwr_i.we ? cwr_i : dwr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o     <= CTRL_RST;
      bright_o   <= '0;
      contrast_o <= '0;
      osd_o      <= '0;
      black_o    <= '0;
      ped_o      <= '0;
    end else if (wr.we) begin
      case (wr.idx)
        A_CTRL:   ctrl_o     <= wr.data[CTRL_W-1:0];
        A_BRIGHT: bright_o   <= wr.data;
        A_CONTR:  contrast_o <= wr.data;
        A_OSD:    osd_o      <= wr.data[OSD_W-1:0];
        A_BLACK:  black_o    <= wr.data[BLK_W-1:0];
        A_PED:    ped_o      <= wr.data[PED_W-1:0];
        default:  ;
      endcase
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gain_o[ch*DW +: DW] <= '0;
        ref_o[ch*DW +: DW]  <= '0;
      end else if (wr.we) begin
        if (wr.idx == A_GAIN + 7'(ch)) gain_o[ch*DW +: DW] <= wr.data;
        if (wr.idx == A_REF + 7'(ch))  ref_o[ch*DW +: DW]  <= wr.data;
      end
    end
  end

  p_commit_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cwr_i.we && dwr_i.we));
endmodule

// File: rtl/vbl_regbuf.sv
module vbl_regbuf
  import vbl_regbuf_pkg::*;
#(
  parameter int DEAD_CYC = 750
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              vblank_edge_i,
  output logic              ack_o,
  output logic              gray_track_off_o,
  output logic              fb_pos_o,
  output logic              video_off_o,
  output logic              osd_off_o,
  output logic [7:0]        bright_o,
  output logic [7:0]        contrast_o,
  output logic [3:0]        osd_gain_o,
  output logic [23:0]       chan_gain_o,
  output logic [23:0]       chan_ref_o,
  output logic [2:0]        ac_black_o,
  output logic [1:0]        ped_depth_o
);
  wr_t  dwr, load, commit;
  logic end_buf, locked, dead;
  logic [CTRL_W-1:0] ctrl;

  vbl_rx_ctrl u_rx (
    .clk_i, .rst_ni, .start_i, .stop_i, .byte_vld_i, .byte_i,
    .locked_i(locked), .dead_i(dead), .ack_o,
    .dwr_o(dwr), .load_o(load), .end_buf_o(end_buf)
  );

  vbl_hold_buf #(.DEAD_CYC(DEAD_CYC)) u_hold (
    .clk_i, .rst_ni, .load_i(load), .end_buf_i(end_buf),
    .vblank_i(vblank_edge_i), .locked_o(locked), .dead_o(dead), .commit_o(commit)
  );

  vbl_reg_file u_regs (
    .clk_i, .rst_ni, .dwr_i(dwr), .cwr_i(commit),
    .ctrl_o(ctrl), .bright_o, .contrast_o, .osd_o(osd_gain_o),
    .gain_o(chan_gain_o), .ref_o(chan_ref_o), .black_o(ac_black_o), .ped_o(ped_depth_o)
  );

  assign gray_track_off_o = ctrl[0];
  assign fb_pos_o         = ctrl[1];
  assign video_off_o      = ctrl[2];
  assign osd_off_o        = ctrl[3];
endmodule

// File: tb/sim_vbl_regbuf.sv
module sim_vbl_regbuf;
  localparam int DEAD = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, bv = 1'b0, vb = 1'b0;
  logic [7:0] bd = '0;
  logic ack, g_off, fbp, v_off, o_off;
  logic [7:0] bri, con;
  logic [3:0] osd;
  logic [23:0] gain, rf;
  logic [2:0] blk;
  logic [1:0] ped;

  int checks = 0, fails = 0;
  logic [7:0] exp_r [0:11];

  always #10 clk = ~clk;

  vbl_regbuf #(.DEAD_CYC(DEAD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .byte_vld_i(bv),
    .byte_i(bd), .vblank_edge_i(vb), .ack_o(ack), .gray_track_off_o(g_off),
    .fb_pos_o(fbp), .video_off_o(v_off), .osd_off_o(o_off), .bright_o(bri),
    .contrast_o(con), .osd_gain_o(osd), .chan_gain_o(gain), .chan_ref_o(rf),
    .ac_black_o(blk), .ped_depth_o(ped)
  );

  function automatic logic [7:0] msk(int i, logic [7:0] d);
    case (i)
      0, 3:    return d & 8'h0F;
      10:      return d & 8'h07;
      11:      return d & 8'h03;
      default: return d;
    endcase
  endfunction

  function automatic logic [7:0] get_reg(int i);
    case (i)
      0:  return {4'b0, o_off, v_off, fbp, g_off};
      1:  return bri;
      2:  return con;
      3:  return {4'b0, osd};
      4, 5, 6: return gain[(i-4)*8 +: 8];
      7, 8, 9: return rf[(i-7)*8 +: 8];
      10: return {5'b0, blk};
      default: return {6'b0, ped};
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic check_regs(input string req);
    bit ok = 1'b1;
    for (int i = 0; i < 12; i++)
      if (get_reg(i) !== exp_r[i]) begin
        ok = 1'b0;
        $display("FAIL %s reg%0d actual=%0h expected=%0h", req, i, get_reg(i), exp_r[i]);
      end
    checks++;
    if (!ok) fails++;
  endtask

  task automatic reset_model();
    for (int i = 0; i < 12; i++) exp_r[i] = 8'h00;
    exp_r[0] = 8'h02;
  endtask

  task automatic cyc_start();
    @(negedge clk); start = 1'b1; @(posedge clk); #1 start = 1'b0;
  endtask
  task automatic cyc_stop(input logic with_vb);
    @(negedge clk); stop = 1'b1; vb = with_vb; @(posedge clk); #1 stop = 1'b0; vb = 1'b0;
  endtask
  task automatic cyc_vb();
    @(negedge clk); vb = 1'b1; @(posedge clk); #1 vb = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask
  task automatic send(input logic [7:0] b, input logic exp_ack, input string req);
    @(negedge clk); bv = 1'b1; bd = b; #2;
    chk(ack === exp_ack, req, ack, exp_ack);
    @(posedge clk); #1 bv = 1'b0;
  endtask

  task automatic rand_txn();
    logic md; int idx, len, ptr; logic [7:0] d, held;
    md  = ($urandom_range(0, 3) == 0);
    idx = $urandom_range(0, 15);
    len = $urandom_range(1, 4);
    ptr = idx; held = '0;
    cyc_start();
    send({md, 7'(idx)}, 1'b1, "R2");
    for (int k = 0; k < len; k++) begin
      d = 8'($urandom);
      if (!md) begin
        send(d, 1'b1, "R3");
        if (ptr <= 11) exp_r[ptr] = msk(ptr, d);
        if (ptr < 11) ptr++;
      end else begin
        send(d, k == 0, "R6");
        if (k == 0) held = d;
      end
    end
    cyc_stop(1'b0);
    if (md) begin
      cyc_vb();
      if (idx <= 11) exp_r[idx] = msk(idx, held);
      idle(DEAD + 2);
    end
    check_regs(md ? "R7" : "R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    reset_model();
    idle(3);
    check_regs("R1");
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    check_regs("R1");

    // R5: power-on flag refuses data
    cyc_start(); send(8'h05, 1'b1, "R5"); send(8'h33, 1'b0, "R5"); cyc_stop(1'b0);
    check_regs("R5");
    cyc_start(); send(8'h00, 1'b1, "R5"); send(8'h0F, 1'b1, "R5"); cyc_stop(1'b0);
    exp_r[0] = 8'h0F; check_regs("R5");

    // R3: direct write, one-cycle latency, auto-increment
    cyc_start(); send(8'h01, 1'b1, "R3");
    send(8'h11, 1'b1, "R3");
    chk(bri === 8'h11, "R3 latency", bri, 8'h11);
    send(8'h22, 1'b1, "R3"); send(8'h35, 1'b1, "R3"); cyc_stop(1'b0);
    exp_r[1] = 8'h11; exp_r[2] = 8'h22; exp_r[3] = 8'h05; check_regs("R3");

    // R3: saturation at last address
    cyc_start(); send(8'h0A, 1'b1, "R3");
    send(8'hFF, 1'b1, "R3"); send(8'hFE, 1'b1, "R3"); send(8'h01, 1'b1, "R3"); cyc_stop(1'b0);
    exp_r[10] = 8'h07; exp_r[11] = 8'h01; check_regs("R3");

    // R4: out of map
    cyc_start(); send(8'h20, 1'b1, "R4"); send(8'h55, 1'b1, "R4"); cyc_stop(1'b0);
    cyc_start(); send(8'h0C, 1'b1, "R4"); send(8'hAA, 1'b1, "R4"); cyc_stop(1'b0);
    check_regs("R4");

    // R6, R8, R7: buffered write
    cyc_start(); send(8'h82, 1'b1, "R6"); send(8'h77, 1'b1, "R6"); send(8'h66, 1'b0, "R6");
    cyc_stop(1'b0);
    check_regs("R6");
    cyc_start(); send(8'h01, 1'b0, "R8"); send(8'h99, 1'b0, "R8"); cyc_stop(1'b0);
    check_regs("R8");
    cyc_vb();
    exp_r[2] = 8'h77; check_regs("R7");
    // R9: last cycle of dead window
    idle(DEAD - 2); cyc_start(); send(8'h01, 1'b0, "R9"); cyc_stop(1'b0);
    idle(DEAD);

    // R9: first cycle after window
    cyc_start(); send(8'h83, 1'b1, "R6"); send(8'h09, 1'b1, "R6"); cyc_stop(1'b0);
    cyc_vb(); exp_r[3] = 8'h09; check_regs("R7");
    idle(DEAD - 1); cyc_start(); send(8'h01, 1'b1, "R9"); send(8'h44, 1'b1, "R9"); cyc_stop(1'b0);
    exp_r[1] = 8'h44; check_regs("R9");

    // R7: strobe in the stop cycle does not commit
    cyc_start(); send(8'h84, 1'b1, "R7"); send(8'hAB, 1'b1, "R7"); cyc_stop(1'b1);
    idle(1); check_regs("R7 strobe at stop");
    cyc_vb(); exp_r[4] = 8'hAB; check_regs("R7");
    idle(DEAD + 2);

    // R7: strobe before the stop does not commit
    cyc_start(); send(8'h85, 1'b1, "R7"); send(8'hCD, 1'b1, "R7"); cyc_vb();
    check_regs("R7 strobe mid");
    cyc_stop(1'b0); check_regs("R7 after stop");
    cyc_vb(); exp_r[5] = 8'hCD; check_regs("R7");
    idle(DEAD + 2);

    // R4: buffered out-of-map takes no lock
    cyc_start(); send(8'h90, 1'b1, "R4"); send(8'h12, 1'b1, "R4"); send(8'h34, 1'b0, "R4");
    cyc_stop(1'b0);
    cyc_start(); send(8'h01, 1'b1, "R4"); send(8'h45, 1'b1, "R4"); cyc_stop(1'b0);
    exp_r[1] = 8'h45; check_regs("R4");

    // R10: reset aborts pending commit
    cyc_start(); send(8'h86, 1'b1, "R10"); send(8'h5A, 1'b1, "R10"); cyc_stop(1'b0);
    @(negedge clk) rst_n = 1'b0;
    reset_model();
    @(negedge clk) rst_n = 1'b1;
    idle(1);
    check_regs("R1");
    cyc_vb(); idle(1); check_regs("R10");
    cyc_start(); send(8'h07, 1'b1, "R10"); send(8'h11, 1'b0, "R10"); cyc_stop(1'b0);
    check_regs("R10");
    cyc_start(); send(8'h00, 1'b1, "R5"); send(8'h02, 1'b1, "R5"); cyc_stop(1'b0);
    check_regs("R5");

    for (int n = 0; n < 60; n++) rand_txn();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule